// File: doc/BRIEF.md
# Burst-Counted SPI Master

This block is a register-mapped SPI master that performs a single chip-select-framed exchange of a programmed length. Software first fills a transmit FIFO. It then writes the total byte count of the exchange and the number of leading bytes that come from that FIFO, and finally sets a start bit. The block lowers the chip select and clocks the total number of bytes in SPI mode 0. Once the transmit quota is used up, the block sends 0x00 filler. Every byte shifted in is pushed into a receive FIFO, including the bytes clocked during the transmit phase, so software skips those.

A small word-addressed register bus with combinational read data controls the block. An internal divider derives SCK from the system clock. Three self-clearing controls are provided: a transmit FIFO reset, a receive FIFO reset, and a global soft reset that software can poll. A typical use is reading a serial flash: send a command and address as the transmit bytes, then read the payload from the receive FIFO after dropping the header bytes.

Top module: `spi_burst_master`

Register map (word address on `bus_addr`): 0 control, 1 start/busy, 2 total count, 3 send count, 4 clock divider, 5 FIFO levels, 6 transmit push, 7 receive pop.

## Requirements
- R1: Control bit 0 is enable and bit 1 is master mode. A start is ignored unless both bits are set and the total count is nonzero. After reset, every register reads 0, CS is high and SCK is low.
- R2: During a burst CS stays low and SCK idles low. SCK gives exactly 8 × total rising edges. Data is MSB first in mode 0: MOSI changes only on a falling SCK edge and MISO is sampled on the rising edge.
- R3: The first `send` bytes of the burst are popped from the transmit FIFO in order. Every later byte is 0x00. A byte that falls within the send count while the FIFO is empty is also sent as 0x00.
- R4: Every received byte, including those clocked during the transmit phase, is pushed into the receive FIFO in arrival order. A read strobe at address 7 returns the head byte in bits [7:0] and pops it.
- R5: Writing 1 to bit 0 of address 1 starts a burst. That bit reads 1 from the write until the burst ends. While the burst runs, further starts and writes to addresses 2, 3 and 4 are ignored.
- R6: Address 5 reads the receive FIFO level in bits [6:0] and the transmit FIFO level in bits [14:8]. Each FIFO holds 64 bytes. A push at address 6 into a full transmit FIFO is dropped.
- R7: Writing 1 to control bit 8 empties the transmit FIFO, and writing 1 to bit 9 empties the receive FIFO. Both bits read back 0.
- R8: Writing 1 to control bit 31 starts a soft reset. The bit reads 1 until the next clock edge and 0 after it. The soft reset aborts any burst (CS high, SCK low), empties both FIFOs and clears every register.
- R9: When bit 12 of address 4 is set, each SCK half period lasts N+1 clocks, where N is bits [7:0]. SCK is then clk / (2 × (N+1)): 0x1000 divides by 2, 0x1001 by 4 and 0x100F by 32. When bit 12 is clear, SCK is clk / 2.
- R10: CS rises exactly one SCK period (2 × (N+1) clocks) after the last falling SCK edge, and the busy bit clears on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at address 7) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
Register writes take effect on the clock edge that captures the strobe. Reads are combinational, so the bench samples each read one nanosecond after the falling edge that follows the write. With a half period of H clocks, the first rising SCK edge comes H clocks after the start edge, and each byte lasts 16·H clocks. CS rises 2·H clocks after the final falling edge. The bench checks these times by timestamping SCK and CS edges and comparing the differences against 2·H clock periods. It reads the counts and FIFO contents only after the start bit has been polled back to 0. The soft-reset bit is read in the cycle straight after its write, when it must be 1, and again one cycle later, when it must have cleared.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic             en, mst, srst;
  logic [CNT_W-1:0] total, send, left, sent;
  logic             div_on;
  logic [7:0]       div_n;
  logic             busy, tail, sck_q, cs_q;
  logic [9:0]       hcnt;
  logic [2:0]       bitn;
  logic [7:0]       tx_sh, rx_sh;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_lvl, rx_lvl;

  wire clr       = rst | srst;
  wire wr_ctrl   = bus_wr && bus_addr == 3'd0;
  wire wr_go     = bus_wr && bus_addr == 3'd1;
  wire cfg_ok    = bus_wr && !busy;

  wire [9:0] half     = div_on ? 10'(div_n) + 10'd1 : 10'd1;
  wire       hit      = hcnt == half - 10'd1;
  wire       tail_hit = hcnt == {half[8:0], 1'b0} - 10'd1;

  wire start_ok  = wr_go && bus_wdata[0] && !busy && en && mst && total != '0;
  wire byte_end  = busy && !tail && hit && sck_q && bitn == 3'd7;
  wire need_next = byte_end && left != CNT_W'(1);
  wire from_fifo = start_ok ? (send != '0) : (sent < send);
  wire take      = (start_ok || need_next) && from_fifo;
  wire tx_pop    = take && tx_lvl != '0;
  wire [7:0] next_byte = tx_pop ? tx_mem[tx_rp] : 8'h00;

  wire tx_push = bus_wr && bus_addr == 3'd6 && tx_lvl != FULL;
  wire rx_push = byte_end && rx_lvl != FULL;
  wire rx_pop  = bus_rd && bus_addr == 3'd7 && rx_lvl != '0;
  wire tx_clr  = wr_ctrl && bus_wdata[8];
  wire rx_clr  = wr_ctrl && bus_wdata[9];

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[30:16]};

  assign sck  = sck_q;
  assign cs_n = cs_q;
  assign mosi = tx_sh[7];

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {srst, 29'd0, mst, en};
      3'd1:    bus_rdata = {31'd0, busy};
      3'd2:    bus_rdata = 32'(total);
      3'd3:    bus_rdata = 32'(send);
      3'd4:    bus_rdata = {19'd0, div_on, 4'd0, div_n};
      3'd5:    bus_rdata = 32'(rx_lvl) | (32'(tx_lvl) << 8);
      3'd7:    bus_rdata = {24'd0, rx_mem[rx_rp]};
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || srst) srst <= 1'b0;
    else             srst <= wr_ctrl && bus_wdata[31];
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_sh;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      en <= 1'b0; mst <= 1'b0;
      total <= '0; send <= '0; div_on <= 1'b0; div_n <= '0;
      busy <= 1'b0; tail <= 1'b0; sck_q <= 1'b0; cs_q <= 1'b1;
      hcnt <= '0; bitn <= '0; left <= '0; sent <= '0;
      tx_sh <= '0; rx_sh <= '0;
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
    end else begin
      if (wr_ctrl) begin
        en  <= bus_wdata[0];
        mst <= bus_wdata[1];
      end
      if (cfg_ok && bus_addr == 3'd2) total <= bus_wdata[CNT_W-1:0];
      if (cfg_ok && bus_addr == 3'd3) send  <= bus_wdata[CNT_W-1:0];
      if (cfg_ok && bus_addr == 3'd4) begin
        div_on <= bus_wdata[12];
        div_n  <= bus_wdata[7:0];
      end

      if (tx_clr) begin
        tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + AW'(1);
        if (tx_pop)  tx_rp <= tx_rp + AW'(1);
        tx_lvl <= tx_lvl + LW'(tx_push) - LW'(tx_pop);
      end

      if (rx_clr) begin
        rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
      end else begin
        if (rx_push) rx_wp <= rx_wp + AW'(1);
        if (rx_pop)  rx_rp <= rx_rp + AW'(1);
        rx_lvl <= rx_lvl + LW'(rx_push) - LW'(rx_pop);
      end

      if (start_ok) begin
        busy  <= 1'b1; tail <= 1'b0; cs_q <= 1'b0; sck_q <= 1'b0;
        hcnt  <= '0;   bitn <= '0;   left <= total;
        sent  <= from_fifo ? CNT_W'(1) : '0;
        tx_sh <= next_byte;
      end else if (busy && !tail) begin
        if (hit) begin
          hcnt  <= '0;
          sck_q <= ~sck_q;
          if (!sck_q) begin
            rx_sh <= {rx_sh[6:0], miso};
          end else if (bitn == 3'd7) begin
            bitn <= '0;
            if (left == CNT_W'(1)) begin
              tail <= 1'b1;
            end else begin
              left  <= left - CNT_W'(1);
              tx_sh <= next_byte;
              if (from_fifo) sent <= sent + CNT_W'(1);
            end
          end else begin
            bitn  <= bitn + 3'd1;
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end else begin
          hcnt <= hcnt + 10'd1;
        end
      end else if (busy) begin
        if (tail_hit) begin
          busy <= 1'b0; tail <= 1'b0; cs_q <= 1'b1; hcnt <= '0;
        end else begin
          hcnt <= hcnt + 10'd1;
        end
      end
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_q && !sck_q)); // R2
  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(sck_q)) |-> $stable(mosi)); // R2
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(en && mst)); // R1
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (rst)
    rx_lvl <= FULL); // R6
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (rst)
    tx_lvl <= FULL); // R6
  AST_SRST_SELFCLR: assert property (@(posedge clk) disable iff (rst)
    srst |=> !srst); // R8

endmodule

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/1ps
module spi_burst_master_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, miso, cs_n;

  always #5 clk = ~clk;

  spi_burst_master u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int errs = 0, checks = 0;
  bit done_flag = 0;

  function automatic logic [7:0] spat(int i); return 8'((i * 37 + 11) & 255); endfunction
  function automatic logic [7:0] txp(int i);  return 8'((i * 29 + 3) & 255);  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int rises = 0;
  realtime rise0 = 0, rise1 = 0, last_fall = 0, cs_rise = 0;
  logic [7:0] cap [128];
  logic [7:0] mb = '0;

  always @(posedge sck) begin
    mb = {mb[6:0], mosi};
    if (rises == 0) rise0 = $realtime;
    if (rises == 1) rise1 = $realtime;
    rises++;
    if (rises % 8 == 0 && rises / 8 <= 128) cap[rises/8-1] = mb;
  end
  always @(negedge sck) last_fall = $realtime;
  always @(posedge cs_n) cs_rise = $realtime;

  logic [7:0] sl_sh = 8'd11;
  int sl_cnt = 0, sl_idx = 0;
  always @(negedge sck or posedge cs_n) begin
    if (cs_n) begin
      sl_cnt = 0; sl_idx = 0; sl_sh = spat(0);
    end else begin
      sl_cnt++;
      if (sl_cnt % 8 == 0) begin
        sl_idx++;
        sl_sh = spat(sl_idx);
      end else begin
        sl_sh = {sl_sh[6:0], 1'b0};
      end
    end
  end
  assign miso = sl_sh[7];

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic popb(output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'd7;
    #1 v = bus_rdata[7:0];
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    forever begin
      rreg(3'd1, v);
      if (!v[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic run_burst(input int tot, input int snd, input int ld, input logic [31:0] dv);
    logic [31:0] v;
    logic [7:0]  b;
    int h, bad;
    h = dv[12] ? int'(dv[7:0]) + 1 : 1;
    wreg(3'd0, 32'h303);
    wreg(3'd4, dv);
    wreg(3'd2, tot);
    wreg(3'd3, snd);
    for (int i = 0; i < ld; i++) wreg(3'd6, {24'd0, txp(i)});
    rises = 0;
    wreg(3'd1, 32'd1);
    rreg(3'd1, v);
    chk(v[0] == 1'b1, "R5 busy after start", v[0], 1);
    wreg(3'd1, 32'd1);
    wait_idle();
    chk(rises == 8 * tot, "R2 sck rising count (second start ignored R5)", rises, 8 * tot);
    bad = 0;
    for (int i = 0; i < tot; i++)
      if (cap[i] !== ((i < snd && i < ld) ? txp(i) : 8'h00)) bad++;
    chk(bad == 0, "R3 mosi bytes mismatched", bad, 0);
    rreg(3'd5, v);
    chk(v[6:0] == 7'(tot), "R4 rx level after burst", v[6:0], tot);
    bad = 0;
    for (int i = 0; i < tot; i++) begin
      popb(b);
      if (b !== spat(i)) bad++;
    end
    chk(bad == 0, "R4 rx bytes mismatched", bad, 0);
    rreg(3'd5, v);
    chk(v[6:0] == 7'd0, "R4 rx level after pops", v[6:0], 0);
    chk(int'(rise1 - rise0) == 20 * h, "R9 sck period ns", int'(rise1 - rise0), 20 * h);
    chk(int'(cs_rise - last_fall) == 20 * h, "R10 cs tail ns", int'(cs_rise - last_fall), 20 * h);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #2000000;
    if (!done_flag) begin
      checks++; errs++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int r;
    logic [31:0] divs [4];
    divs[0] = 32'h0000; divs[1] = 32'h1000; divs[2] = 32'h1001; divs[3] = 32'h100F;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    chk(cs_n == 1'b1 && sck == 1'b0, "R1 reset pins", {cs_n, sck}, 2'b10);
    rreg(3'd0, v); chk(v == 0, "R1 reset ctrl", v, 0);
    rreg(3'd5, v); chk(v == 0, "R1 reset levels", v, 0);
    rreg(3'd1, v); chk(v == 0, "R1 reset busy", v, 0);

    rises = 0;
    wreg(3'd0, 32'h1); wreg(3'd2, 3); wreg(3'd1, 1);
    rreg(3'd1, v); chk(v[0] == 0, "R1 start without master", v[0], 0);
    wreg(3'd0, 32'h2); wreg(3'd1, 1);
    rreg(3'd1, v); chk(v[0] == 0, "R1 start without enable", v[0], 0);
    wreg(3'd0, 32'h3); wreg(3'd2, 0); wreg(3'd1, 1);
    rreg(3'd1, v); chk(v[0] == 0, "R1 start with zero total", v[0], 0);
    repeat (20) @(negedge clk);
    chk(rises == 0 && cs_n == 1'b1, "R1 no activity when gated", rises, 0);

    for (int d = 0; d < 4; d++) begin
      run_burst(1, 1, 1, divs[d]);
      run_burst(4, 4, 4, divs[d]);
      run_burst(6, 2, 2, divs[d]);
      run_burst(5, 0, 0, divs[d]);
      run_burst(8, 5, 3, divs[d]);
    end
    run_burst(64, 4, 4, 32'h1000);
    run_burst(64, 64, 64, 32'h1001);

    wreg(3'd0, 32'h103);
    for (int i = 0; i < 70; i++) wreg(3'd6, i);
    rreg(3'd5, v); chk(v[14:8] == 7'd64, "R6 tx level saturates at depth", v[14:8], 64);
    wreg(3'd0, 32'h103);
    rreg(3'd5, v); chk(v[14:8] == 7'd0, "R7 tx fifo reset", v[14:8], 0);
    rreg(3'd0, v); chk(v == 32'h3, "R7 reset bits read 0", v, 3);

    wreg(3'd4, 32'h0); wreg(3'd2, 5); wreg(3'd3, 0);
    rises = 0;
    wreg(3'd1, 1);
    wreg(3'd2, 9);
    wreg(3'd4, 32'h100F);
    wait_idle();
    rreg(3'd2, v); chk(v == 5, "R5 total write ignored while busy", v, 5);
    rreg(3'd4, v); chk(v == 0, "R5 divider write ignored while busy", v, 0);
    chk(rises == 40, "R5 burst length unaffected", rises, 40);
    rreg(3'd5, v); chk(v[6:0] == 7'd5, "R4 rx level before reset", v[6:0], 5);
    wreg(3'd0, 32'h203);
    rreg(3'd5, v); chk(v[6:0] == 7'd0, "R7 rx fifo reset", v[6:0], 0);

    wreg(3'd4, 32'h100F); wreg(3'd2, 40); wreg(3'd3, 0);
    wreg(3'd6, 32'h55);
    rises = 0;
    wreg(3'd1, 1);
    repeat (100) @(negedge clk);
    wreg(3'd0, 32'h8000_0003);
    rreg(3'd0, v); chk(v[31] == 1'b1, "R8 soft reset bit reads 1", v[31], 1);
    @(negedge clk);
    rreg(3'd0, v); chk(v == 0, "R8 soft reset self clears and clears ctrl", v, 0);
    rreg(3'd2, v); chk(v == 0, "R8 total cleared", v, 0);
    rreg(3'd1, v); chk(v == 0, "R8 burst aborted", v, 0);
    rreg(3'd5, v); chk(v == 0, "R8 fifos emptied", v, 0);
    chk(cs_n == 1'b1 && sck == 1'b0, "R8 pins idle", {cs_n, sck}, 2'b10);
    r = rises;
    repeat (50) @(negedge clk);
    chk(rises == r, "R8 no sck after abort", rises, r);

    done_flag = 1;
    summary();
    $finish;
  end

endmodule